// File: doc/BRIEF.md
# Multichannel PWM Generator with Shared-Word Duty Loading

This block drives a bank of pulse-width-modulated outputs from one free-running timebase. The timebase counts from zero up to an effective top value and then wraps, so every period lasts top+1 clock cycles. Each channel compares the count against its own active duty value. A channel is high from count zero through its duty value and low for the rest of the period. A duty of zero keeps it low.

Software loads duty values through one shared path. It first writes a single duty word, then writes a channel bitmask. Every channel whose mask bit is 1 receives a copy of that word. The mask write is accepted only while the ready flag is high. A small loader state machine has two states: `LD_IDLE`, where ready is high, and `LD_LOAD`, where ready is low. Its transitions are named `ACCEPT` (an accepted mask write moves it from `LD_IDLE` to `LD_LOAD`) and `FINISH` (it always returns from `LD_LOAD` to `LD_IDLE` after one cycle).

Loaded values wait in a pending register. They become active only when the period restarts, so no pulse is cut short. To spread I/O switching, odd-indexed channels update on the falling clock edge and even-indexed channels update on the rising edge. A clear control restarts the timebase.

Top module: `pwm_ilink`

## Requirements
- R1: After reset, all outputs are low, ready is high, and the top register, shared word, pending duties and active duties are zero.
- R2: The count runs 0, 1, …, T, 0, … where T is the effective top value, giving a period of T+1 cycles. A newly written top value becomes the effective top when the count next wraps to zero.
- R3: A channel is high exactly when its active duty D is nonzero and count ≤ D. This gives D+1 high cycles per period for 1 ≤ D ≤ T (so D=1 gives two cycles), T+1 high cycles and no low cycles for D ≥ T, and no high cycles for D=0.
- R4: Even-indexed channels take their new level on the rising clock edge. Odd-indexed channels take it on the following falling edge, half a cycle later.
- R5: An accepted mask write (address 2) copies the shared duty word (address 1) into the pending duty of every channel whose mask bit is 1. Channels whose mask bit is 0 keep their pending duty.
- R6: After an accepted mask write, ready is low for exactly one cycle. A mask write that arrives while ready is low is ignored and changes no duty.
- R7: A pending duty becomes active only at the edge where the count wraps to zero, or on a clear. The active duty stays fixed for the rest of the period.
- R8: Writing 1 to bit 0 at address 3 sets the count to zero, reloads the effective top from the top register, and activates the pending duties, all at the same edge.
- R9: Register addresses are: 0 for the top value, 1 for the shared duty word, 2 for the channel mask, and 3 for control. The duty registers cannot be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 top, 1 word, 2 mask, 3 control) |
| wr_data | input | DW (8) | Write data |
| ready | output | 1 | High when a mask write will be accepted |
| pwm_o | output | NCH (8) | Channel outputs |

## Verification
Directed periods measure the number of high cycles for duty 0, 1, a middle value, the top value and a value above the top. These separate the zero case, the two-cycle jump at duty 1, the one-cycle-per-step rule and saturation. A partial mask tells selected channels from unselected ones. A second mask sent during the busy cycle shows whether writes are dropped while ready is low. Random register writes with a small top value then exercise mid-period loads, clears, and top changes landing on wrap edges, all against a cycle model. Each cycle is sampled twice so that the half-cycle lag of odd channels is visible.

// File: rtl/pwm_ilink_pkg.sv
package pwm_ilink_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_TOP  = 2'd0;
    localparam logic [ADDR_W-1:0] REG_WORD = 2'd1;
    localparam logic [ADDR_W-1:0] REG_MASK = 2'd2;
    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd3;

    localparam int CTRL_CLR_BIT = 0;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_LOAD = 1'b1
    } ld_state_e;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          top_wr,
    input  logic [CW-1:0] top_wdata,
    input  logic          clr,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_d,
    output logic          restart
);

    logic [CW-1:0] top_q;
    logic [CW-1:0] eff_q;
    logic [CW-1:0] eff_d;
    logic          at_top;

    assign at_top  = (cnt_q >= eff_q);
    assign restart = clr | at_top;

    always_comb begin
        cnt_d = cnt_q + {{(CW-1){1'b0}}, 1'b1};
        eff_d = eff_q;
        if (restart) begin
            cnt_d = '0;
            eff_d = top_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            eff_q <= '0;
            top_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            eff_q <= eff_d;
            if (top_wr) begin
                top_q <= top_wdata;
            end
        end
    end

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= eff_q);

    p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == eff_q) |=> (cnt_q == '0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_q < eff_q) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && eff_q == $past(top_q)));

endmodule

// File: rtl/pwm_dutyload.sv
module pwm_dutyload
    import pwm_ilink_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_wr,
    input  logic [CW-1:0]           word_wdata,
    input  logic                    mask_wr,
    input  logic [NCH-1:0]          mask_wdata,
    output logic                    ready,
    output logic [NCH-1:0][CW-1:0]  pend_q
);

    ld_state_e      state_q;
    ld_state_e      state_d;
    logic [CW-1:0]  word_q;
    logic [NCH-1:0] mask_q;
    logic           accept;
    logic           load_en;

    assign accept = mask_wr && (state_q == LD_IDLE);

    // Next-state logic: ACCEPT moves IDLE to LOAD, FINISH returns to IDLE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE: if (accept) state_d = LD_LOAD;
            LD_LOAD: state_d = LD_IDLE;
            default: state_d = LD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        ready   = 1'b0;
        load_en = 1'b0;
        unique case (state_q)
            LD_IDLE: ready   = 1'b1;
            LD_LOAD: load_en = 1'b1;
            default: ready   = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            mask_q <= '0;
        end else begin
            if (word_wr) begin
                word_q <= word_wdata;
            end
            if (accept) begin
                mask_q <= mask_wdata;
            end
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_pend
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[i] <= '0;
            end else if (load_en && mask_q[i]) begin
                pend_q[i] <= word_q;
            end
        end

        p_unselected_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(load_en && mask_q[i]) |=> $stable(pend_q[i]));
    end

    p_busy_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);

    p_accept_drops_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && mask_wr) |=> !ready);

    p_busy_mask_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(mask_q));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int CW      = 8,
    parameter bit FALLING = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] pend,
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] cnt_d,
    output logic          pwm_o
);

    logic [CW-1:0] act_q;
    logic [CW-1:0] act_d;

    assign act_d = restart ? pend : act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    if (FALLING) begin : g_fall
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pwm_o <= 1'b0;
            end else begin
                pwm_o <= (act_q != '0) && (cnt_q <= act_q);
            end
        end
    end else begin : g_rise
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pwm_o <= 1'b0;
            end else begin
                pwm_o <= (act_d != '0) && (cnt_d <= act_d);
            end
        end
    end

    p_zero_duty_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == '0) |-> !pwm_o);

    p_duty_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> $stable(act_q));

endmodule

// File: rtl/pwm_ilink.sv
module pwm_ilink
    import pwm_ilink_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 8,
    parameter int DW  = (CW > NCH) ? CW : NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              ready,
    output logic [NCH-1:0]    pwm_o
);

    logic                   top_wr;
    logic                   word_wr;
    logic                   mask_wr;
    logic                   clr;
    logic [CW-1:0]          cnt_q;
    logic [CW-1:0]          cnt_d;
    logic                   restart;
    logic [NCH-1:0][CW-1:0] pend;

    assign top_wr  = wr_en && (wr_addr == REG_TOP);
    assign word_wr = wr_en && (wr_addr == REG_WORD);
    assign mask_wr = wr_en && (wr_addr == REG_MASK);
    assign clr     = wr_en && (wr_addr == REG_CTRL) && wr_data[CTRL_CLR_BIT];

    pwm_timebase #(.CW(CW)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .top_wr    (top_wr),
        .top_wdata (wr_data[CW-1:0]),
        .clr       (clr),
        .cnt_q     (cnt_q),
        .cnt_d     (cnt_d),
        .restart   (restart)
    );

    pwm_dutyload #(.NCH(NCH), .CW(CW)) u_ld (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_wr    (word_wr),
        .word_wdata (wr_data[CW-1:0]),
        .mask_wr    (mask_wr),
        .mask_wdata (wr_data[NCH-1:0]),
        .ready      (ready),
        .pend_q     (pend)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_chan #(.CW(CW), .FALLING((i % 2) == 1)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .pend    (pend[i]),
            .cnt_q   (cnt_q),
            .cnt_d   (cnt_d),
            .pwm_o   (pwm_o[i])
        );
    end

    p_period_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && pend[0] != '0) |=> pwm_o[0]);

endmodule

// File: tb/tb_pwm_ilink.sv
module tb_pwm_ilink;

    localparam int NCH = 8;
    localparam int CW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic           ready;
    logic [NCH-1:0] pwm_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    logic [CW-1:0] m_top, m_word, m_cnt, m_eff;
    logic [CW-1:0] m_pend [NCH];
    logic [CW-1:0] m_act  [NCH];
    logic [NCH-1:0] m_mask;
    logic           m_load;
    logic [NCH-1:0] prev_exp;
    int             hi [NCH];

    always #5 clk = ~clk;

    pwm_ilink dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ready(ready), .pwm_o(pwm_o)
    );

    function automatic logic [NCH-1:0] expect_pwm();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++)
            v[i] = (m_act[i] != 0) && (m_cnt <= m_act[i]);
        return v;
    endfunction

    function automatic int expect_high(int d, int t);
        if (d == 0) return 0;
        if (d >= t) return t + 1;
        return d + 1;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_update(logic we, logic [1:0] a, logic [7:0] d);
        logic [CW-1:0] old_pend [NCH];
        logic [CW-1:0] old_top, old_word;
        for (int i = 0; i < NCH; i++) old_pend[i] = m_pend[i];
        old_top = m_top;
        old_word = m_word;
        if ((we && a == 2'd3 && d[0]) || m_cnt >= m_eff) begin
            m_cnt = 0;
            m_eff = old_top;
            for (int i = 0; i < NCH; i++) m_act[i] = old_pend[i];
        end else begin
            m_cnt = m_cnt + 1'b1;
        end
        if (m_load) begin
            for (int i = 0; i < NCH; i++)
                if (m_mask[i]) m_pend[i] = old_word;
            m_load = 0;
        end else if (we && a == 2'd2) begin
            m_mask = d;
            m_load = 1;
        end
        if (we && a == 2'd0) m_top = d;
        if (we && a == 2'd1) m_word = d;
    endtask

    task automatic step(logic we, logic [1:0] a, logic [7:0] d);
        logic [NCH-1:0] e;
        logic [NCH-1:0] early;
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_update(we, a, d);
        e = expect_pwm();
        #2;
        // R4: even channels already new, odd ones still show previous level
        for (int i = 0; i < NCH; i++) early[i] = (i % 2) ? prev_exp[i] : e[i];
        chk(pwm_o === early, "R4 half-cycle", pwm_o, early);
        #4;
        wr_en = 1'b0;
        chk(pwm_o === e, "R2/R3/R5/R7/R8 model", pwm_o, e);
        chk(ready === !m_load, "R6 ready", ready, !m_load);
        for (int i = 0; i < NCH; i++) hi[i] += pwm_o[i];
        prev_exp = e;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(1'b0, 2'd0, 8'd0);
    endtask

    task automatic clear_hi();
        for (int i = 0; i < NCH; i++) hi[i] = 0;
    endtask

    task automatic load(logic [7:0] w, logic [7:0] mask);
        step(1'b1, 2'd1, w);
        step(1'b1, 2'd2, mask);
        idle(1);
    endtask

    // Set duty d on all channels, restart, count highs over one period
    task automatic duty_period(int d, int t);
        load(d[7:0], 8'hFF);
        step(1'b1, 2'd3, 8'h01);
        clear_hi();
        idle(t + 1);
        for (int i = 0; i < NCH; i++)
            chk(hi[i] == expect_high(d, t), "R3 high count", hi[i], expect_high(d, t));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        m_top = 0; m_word = 0; m_cnt = 0; m_eff = 0; m_mask = 0; m_load = 0;
        prev_exp = 0;
        for (int i = 0; i < NCH; i++) begin m_pend[i] = 0; m_act[i] = 0; end
        clear_hi();
        repeat (3) @(posedge clk);
        #6;
        // R1: reset state
        chk(pwm_o === '0, "R1 outputs", pwm_o, 0);
        chk(ready === 1'b1, "R1 ready", ready, 1);
        rst_n = 1'b1;
        idle(3);
        chk(pwm_o === '0, "R1 outputs stay low", pwm_o, 0);

        // R9 top at address 0, R2 period with top 5
        step(1'b1, 2'd0, 8'd5);
        duty_period(1, 5);   // R3 two-cycle jump
        duty_period(3, 5);
        duty_period(5, 5);   // R3 duty = top
        duty_period(9, 5);   // R3 above top
        duty_period(0, 5);   // R3 zero

        // R5 partial mask: channels 0-3 get 2, 4-7 keep 0
        load(8'd2, 8'h0F);
        step(1'b1, 2'd3, 8'h01);
        clear_hi();
        idle(6);
        for (int i = 0; i < NCH; i++)
            chk(hi[i] == (i < 4 ? 3 : 0), "R5 mask select", hi[i], i < 4 ? 3 : 0);

        // R6 second mask during busy cycle is ignored
        step(1'b1, 2'd1, 8'd4);
        step(1'b1, 2'd2, 8'h01);
        step(1'b1, 2'd2, 8'hF0);
        chk(ready === 1'b1, "R6 ready back", ready, 1);
        step(1'b1, 2'd3, 8'h01);
        clear_hi();
        idle(6);
        chk(hi[0] == 5, "R6 accepted ch0", hi[0], 5);
        chk(hi[7] == 0, "R6 ignored ch7", hi[7], 0);

        // R7 mid-period load with top 9: old duty kept until wrap
        step(1'b1, 2'd0, 8'd9);
        step(1'b1, 2'd3, 8'h01);
        idle(10);
        clear_hi();
        load(8'd8, 8'hFF);
        idle(7);
        chk(hi[0] == 5, "R7 old duty through period", hi[0], 5);

        // constrained random
        seed = $urandom(32'd20240611);
        for (int k = 0; k < 4000; k++) begin
            int r;
            logic [1:0] a;
            logic [7:0] d;
            r = $urandom % 100;
            if (r < 55) begin
                step(1'b0, 2'd0, 8'd0);
            end else begin
                a = 2'($urandom % 4);
                d = 8'($urandom);
                if (a == 2'd0) d = 8'($urandom % 12);
                if (a == 2'd1) d = 8'($urandom % 14);
                if (a == 2'd3 && ($urandom % 3 != 0)) d[0] = 1'b0;
                step(1'b1, a, d);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule